// File: doc/BRIEF.md
# Programmable Interrupt Mode Controller

This block gathers a small set of interrupt sources, 16 by default, and gives each one its own 8-bit mode byte. The byte says whether the source counts as a request on a low level, a high level, a falling edge or a rising edge. It also says whether the source is a prioritised CPU interrupt or a trigger for one of four DMA channels. Inputs pass through a two-flop synchronizer. Edge events are held in a pending bit. Level requests follow the synchronized input.

CPU-routed requests are arbitrated by priority. The block presents the winner as a request line, a 3-bit level and a 10-bit vector. The vector holds the source number in bits [9:4]. Software clears an edge-held request by writing that source number to a write-only clear register. DMA-routed requests raise the trigger of their selected channel until that channel acknowledges. Software reaches the mode registers, the vector and the clear register through a simple word-addressed register port. Writes take effect on the clock edge. Reads return data combinationally from the current address.

Top module: `intc_mode_ctrl`

## Requirements
- R1: Mode registers live at word addresses 0 to NSRC/4-1. Each holds four mode bytes, with the lowest-numbered source in bits [7:0]. Within a byte, bits [2:0] are the level/channel field, bit 3 selects DMA routing, bits [5:4] select sensitivity, and bits [7:6] always read 0. All mode fields reset to 0.
- R2: Source 0 is the software-set source. Its sensitivity field always reads 00, whatever is written.
- R3: Sensitivity 00 makes a source request while its synchronized input is low. Sensitivity 01 makes it request while the input is high. No state is held in either case.
- R4: Sensitivity 10 latches a falling edge and 11 latches a rising edge into a pending bit. The request stays after the input returns to its old value.
- R5: With the DMA bit 0, a level field of 0 disables the source and values 1 to 7 are priorities. cpu_irq is high when any enabled CPU-routed source requests, and cpu_level gives the winner's priority.
- R6: The highest priority wins, and ties go to the lower source number. cpu_vector equals the winner's number shifted left by 4. cpu_irq, cpu_level and cpu_vector all read 0 when nothing requests. The vector is also readable at word address NSRC/4.
- R7: Writing n to bits [5:0] at word address NSRC/4+1 clears the edge-pending bit of source n only. It does not affect a level-mode request or any other source.
- R8: With the DMA bit 1, level field values 0 to 3 route the request to dma_trig[value]. Values 4 to 7 raise no trigger. A DMA-routed source never raises cpu_irq.
- R9: A pulse on dma_ack[c] clears the edge-pending bits of the sources routed to channel c. A pulse on any other channel leaves them set.
- R10: A level-mode input change shows on the outputs after the 3rd rising edge, and an edge-mode event after the 4th. A clear write or an acknowledge shows after the 2nd edge, counting the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_in | input | NSRC | Raw interrupt source inputs |
| dma_ack | input | 4 | Per-channel DMA acknowledge pulses |
| cpu_irq | output | 1 | CPU interrupt request |
| cpu_level | output | 3 | Priority of the winning source |
| cpu_vector | output | 10 | Vector of the winning source |
| dma_trig | output | 4 | DMA channel trigger lines |

## Verification
A level input is due on the outputs three clock edges after it is driven, and an edge event is due four edges after it is driven. A mode write, a clear write or an acknowledge is due two edges after it is driven. The bench drives every input on a falling edge. Dedicated latency checks count rising edges and sample on the falling edge just before and just after the due edge. The table walk and the other directed cases wait several cycles beyond the longest latency before sampling, so they check only the settled result.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NCH = 4;

    localparam logic [1:0] SENS_LOW  = 2'b00;
    localparam logic [1:0] SENS_HIGH = 2'b01;
    localparam logic [1:0] SENS_FALL = 2'b10;
    localparam logic [1:0] SENS_RISE = 2'b11;

    // stored part of one mode byte (bits [7:6] are not kept)
    typedef struct packed {
        logic [1:0] sens;
        logic       dm;
        logic [2:0] lvl;
    } mode_t;

    function automatic logic [7:0] mode_to_byte(mode_t m);
        return {2'b00, m.sens, m.dm, m.lvl};
    endfunction

    function automatic mode_t byte_to_mode(logic [7:0] b);
        mode_t m;
        m.sens = b[5:4];
        m.dm   = b[3];
        m.lvl  = b[2:0];
        return m;
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NSRC = 16,
    parameter int IDXW = 6
) (
    input  logic [NSRC-1:0]   cand,
    input  logic [NSRC*3-1:0] lvl_flat,
    output logic              found,
    output logic [2:0]        best_lvl,
    output logic [IDXW-1:0]   best_idx
);
    // scan from the top down; ">=" lets a lower index take a tie
    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i] && (lvl_flat[i*3 +: 3] >= best_lvl)) begin
                found    = 1'b1;
                best_lvl = lvl_flat[i*3 +: 3];
                best_idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_dma_route.sv
module intc_dma_route #(
    parameter int NSRC = 16,
    parameter int NCH  = 4,
    parameter int CW   = $clog2(NCH)
) (
    input  logic [NSRC-1:0]    cand,
    input  logic [NSRC*CW-1:0] chan_flat,
    output logic [NCH-1:0]     trig
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < NSRC; i++) begin
                if (cand[i] && (chan_flat[i*CW +: CW] == CW'(c))) hit = 1'b1;
            end
        end
        assign trig[c] = hit;
    end
endmodule

// File: rtl/intc_mode_ctrl.sv
module intc_mode_ctrl
    import intc_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int AW   = $clog2(NSRC / 4 + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    input  logic [NSRC-1:0] irq_in,
    input  logic [NCH-1:0]  dma_ack,
    output logic            cpu_irq,
    output logic [2:0]      cpu_level,
    output logic [9:0]      cpu_vector,
    output logic [NCH-1:0]  dma_trig
);
    localparam int NREG     = NSRC / 4;
    localparam int IDXW     = 6;
    localparam int CW       = $clog2(NCH);
    localparam int VEC_ADDR = NREG;
    localparam int CLR_ADDR = NREG + 1;

    typedef struct packed {
        mode_t [NSRC-1:0] mode;
        logic  [NSRC-1:0] prev;
        logic  [NSRC-1:0] pend;
        logic             irq;
        logic  [2:0]      lvl;
        logic  [9:0]      vec;
        logic  [NCH-1:0]  trig;
    } state_t;

    state_t q, d;

    logic [NSRC-1:0]    sync_v;
    logic [NSRC-1:0]    cpu_cand, dma_cand;
    logic [NSRC*3-1:0]  lvl_flat;
    logic [NSRC*CW-1:0] chan_flat;
    logic               win_found;
    logic [2:0]         win_lvl;
    logic [IDXW-1:0]    win_idx;
    logic [NCH-1:0]     trig_c;

    intc_sync #(.W(NSRC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .dout (sync_v)
    );

    intc_arbiter #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
        .cand    (cpu_cand),
        .lvl_flat(lvl_flat),
        .found   (win_found),
        .best_lvl(win_lvl),
        .best_idx(win_idx)
    );

    intc_dma_route #(.NSRC(NSRC), .NCH(NCH), .CW(CW)) u_route (
        .cand     (dma_cand),
        .chan_flat(chan_flat),
        .trig     (trig_c)
    );

    always_comb begin
        d = q;
        for (int i = 0; i < NSRC; i++) begin
            logic  lvl_hit, edge_hit, is_edge, enabled, req, clr_hit, ack_hit;
            mode_t m;
            m        = q.mode[i];
            lvl_hit  = m.sens[0] ? sync_v[i] : ~sync_v[i];
            edge_hit = m.sens[0] ? (sync_v[i] & ~q.prev[i]) : (~sync_v[i] & q.prev[i]);
            is_edge  = m.sens[1];
            enabled  = m.dm ? ~m.lvl[2] : (m.lvl != 3'd0);
            req      = is_edge ? q.pend[i] : lvl_hit;

            cpu_cand[i]          = req & ~m.dm & (m.lvl != 3'd0);
            dma_cand[i]          = req & m.dm & ~m.lvl[2];
            lvl_flat[i*3 +: 3]   = m.lvl;
            chan_flat[i*CW +: CW] = m.lvl[CW-1:0];

            clr_hit  = wr_en && (addr == AW'(CLR_ADDR)) && (wdata[5:0] == 6'(i));
            ack_hit  = m.dm & ~m.lvl[2] & dma_ack[m.lvl[CW-1:0]];
            d.pend[i] = (q.pend[i] & ~clr_hit & ~ack_hit) | (is_edge & enabled & edge_hit);
        end
        d.prev = sync_v;

        for (int r = 0; r < NREG; r++) begin
            if (wr_en && (addr == AW'(r))) begin
                for (int b = 0; b < 4; b++) begin
                    d.mode[r*4 + b] = byte_to_mode(wdata[b*8 +: 8]);
                end
            end
        end
        d.mode[0].sens = SENS_LOW;

        d.irq  = win_found;
        d.lvl  = win_found ? win_lvl : 3'd0;
        d.vec  = win_found ? {win_idx, 4'b0000} : 10'd0;
        d.trig = trig_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (addr == AW'(r)) begin
                for (int b = 0; b < 4; b++) begin
                    rdata[b*8 +: 8] = mode_to_byte(q.mode[r*4 + b]);
                end
            end
        end
        if (addr == AW'(VEC_ADDR)) rdata = {22'd0, q.vec};
    end

    assign cpu_irq    = q.irq;
    assign cpu_level  = q.lvl;
    assign cpu_vector = q.vec;
    assign dma_trig   = q.trig;
endmodule

// File: rtl/intc_mode_ctrl_chk.sv
module intc_mode_ctrl_chk #(
    parameter int NSRC = 16,
    parameter int AW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic [31:0]   rdata,
    input logic          cpu_irq,
    input logic [2:0]    cpu_level,
    input logic [9:0]    cpu_vector
);
    localparam int NREG = NSRC / 4;

    // R5
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (cpu_level != 3'd0));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_irq |-> (cpu_level == 3'd0 && cpu_vector == 10'd0));

    // R6
    vec_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_vector[3:0] == 4'd0);

    // R1
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(addr) < NREG) |-> ((rdata & 32'hC0C0_C0C0) == 32'd0));

    // R2
    sw_sens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> (rdata[5:4] == 2'b00));
endmodule

bind intc_mode_ctrl intc_mode_ctrl_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rdata     (rdata),
    .cpu_irq   (cpu_irq),
    .cpu_level (cpu_level),
    .cpu_vector(cpu_vector)
);

// File: tb/intc_mode_ctrl_test.sv
`timescale 1ns/1ps
module intc_mode_ctrl_test;
    localparam int NSRC = 16;
    localparam int AW   = 3;
    localparam int VECA = 4;
    localparam int CLRA = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NSRC-1:0] irq_in = '0;
    logic [3:0]      dma_ack = '0;
    logic            cpu_irq;
    logic [2:0]      cpu_level;
    logic [9:0]      cpu_vector;
    logic [3:0]      dma_trig;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    intc_mode_ctrl #(.NSRC(NSRC), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .dma_ack(dma_ack), .cpu_irq(cpu_irq),
        .cpu_level(cpu_level), .cpu_vector(cpu_vector), .dma_trig(dma_trig)
    );

    typedef struct packed {
        logic [3:0] src;
        logic [7:0] mode;
        logic       base;
        logic       fin;
        logic       irq;
        logic [2:0] lvl;
        logic [3:0] trig;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{4'd3,  8'h15, 1'b0, 1'b1, 1'b1, 3'd5, 4'b0000},  // R3 high level
        '{4'd3,  8'h15, 1'b1, 1'b0, 1'b0, 3'd0, 4'b0000},  // R3 high level idle
        '{4'd5,  8'h02, 1'b1, 1'b0, 1'b1, 3'd2, 4'b0000},  // R3 low level
        '{4'd7,  8'h37, 1'b0, 1'b1, 1'b1, 3'd7, 4'b0000},  // R4 rising
        '{4'd7,  8'h27, 1'b0, 1'b1, 1'b0, 3'd0, 4'b0000},  // R4 falling, wrong edge
        '{4'd9,  8'h21, 1'b1, 1'b0, 1'b1, 3'd1, 4'b0000},  // R4 falling
        '{4'd2,  8'h10, 1'b0, 1'b1, 1'b0, 3'd0, 4'b0000},  // R5 level 0 disabled
        '{4'd4,  8'h1A, 1'b0, 1'b1, 1'b0, 3'd0, 4'b0100},  // R8 channel 2
        '{4'd4,  8'h1E, 1'b0, 1'b1, 1'b0, 3'd0, 4'b0000},  // R8 reserved value 6
        '{4'd6,  8'h38, 1'b0, 1'b1, 1'b0, 3'd0, 4'b0001},  // R8 rising to channel 0
        '{4'd15, 8'h13, 1'b0, 1'b1, 1'b1, 3'd3, 4'b0000},  // R6 top source vector
        '{4'd0,  8'h34, 1'b1, 1'b0, 1'b1, 3'd4, 4'b0000}   // R2 forced low level
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] dat);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = dat;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] dat);
        @(negedge clk);
        addr = AW'(a);
        #1 dat = rdata;
    endtask

    task automatic ack(input logic [3:0] m);
        @(negedge clk);
        dma_ack = m;
        @(negedge clk);
        dma_ack = '0;
    endtask

    task automatic clean();
        for (int r = 0; r < 4; r++) wr(r, 32'd0);
        @(negedge clk);
        irq_in = '0;
        for (int s = 0; s < NSRC; s++) wr(CLRA, 32'(s));
        ack(4'hF);
        waitc(4);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        waitc(3);
        rst_n = 1'b1;
        waitc(2);

        // R1 reset state
        check("R1 reset irq", 32'(cpu_irq), 32'd0);
        check("R1 reset trig", 32'(dma_trig), 32'd0);
        for (int r = 0; r < 4; r++) begin
            rd(r, v);
            check("R1 reset mode", v, 32'd0);
        end

        // R1 R2 readback masks
        wr(1, 32'hFFFF_FFFF);
        rd(1, v); check("R1 readback", v, 32'h3F3F_3F3F);
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); check("R2 source 0 sensitivity", v, 32'h3F3F_3F0F);
        clean();

        // table walk
        for (int k = 0; k < NV; k++) begin
            vec_t e;
            e = TBL[k];
            @(negedge clk);
            irq_in = '0;
            irq_in[e.src] = e.base;
            waitc(6);
            wr(int'(e.src) / 4, 32'(e.mode) << (8 * (int'(e.src) % 4)));
            waitc(3);
            irq_in[e.src] = e.fin;
            waitc(6);
            check($sformatf("R5 irq entry %0d", k), 32'(cpu_irq), 32'(e.irq));
            check($sformatf("R6 level entry %0d", k), 32'(cpu_level), 32'(e.lvl));
            check($sformatf("R6 vector entry %0d", k), 32'(cpu_vector),
                  e.irq ? (32'(e.src) << 4) : 32'd0);
            check($sformatf("R8 trig entry %0d", k), 32'(dma_trig), 32'(e.trig));
            clean();
        end

        // R6 arbitration and tie break
        wr(0, 32'h0015_0000);
        wr(2, 32'h0015_0000);
        wr(3, 32'h0000_0013);
        @(negedge clk);
        irq_in[2] = 1'b1; irq_in[10] = 1'b1; irq_in[12] = 1'b1;
        waitc(6);
        check("R6 tie vector", 32'(cpu_vector), 32'h20);
        check("R6 tie level", 32'(cpu_level), 32'd5);
        rd(VECA, v); check("R6 vector read", v, 32'h20);
        irq_in[2] = 1'b0;
        waitc(6);
        check("R6 next vector", 32'(cpu_vector), 32'hA0);
        irq_in[10] = 1'b0;
        waitc(6);
        check("R6 lower prio vector", 32'(cpu_vector), 32'hC0);
        check("R6 lower prio level", 32'(cpu_level), 32'd3);
        clean();

        // R10 level latency
        wr(0, 32'h1500_0000);
        waitc(4);
        irq_in[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 level not early", 32'(cpu_irq), 32'd0);
        @(posedge clk); @(negedge clk);
        check("R10 level due edge 3", 32'(cpu_irq), 32'd1);
        clean();

        // R10 edge latency
        wr(0, 32'h3500_0000);
        waitc(4);
        irq_in[3] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 edge not early", 32'(cpu_irq), 32'd0);
        @(posedge clk); @(negedge clk);
        check("R10 edge due edge 4", 32'(cpu_irq), 32'd1);
        clean();

        // R4 R7 latch and clear
        wr(1, 32'h3400_0000);
        waitc(2);
        irq_in[7] = 1'b1;
        waitc(2);
        irq_in[7] = 1'b0;
        waitc(8);
        check("R4 latched after input drop", 32'(cpu_vector), 32'h70);
        wr(CLRA, 32'd8);
        waitc(3);
        check("R7 other clear ignored", 32'(cpu_irq), 32'd1);
        wr(CLRA, 32'd7);
        @(negedge clk);
        check("R10 clear due edge 2", 32'(cpu_irq), 32'd0);
        clean();

        // R7 level request ignores clear
        wr(0, 32'h1200_0000);
        @(negedge clk); irq_in[3] = 1'b1;
        waitc(6);
        wr(CLRA, 32'd3);
        waitc(4);
        check("R7 level unaffected", 32'(cpu_vector), 32'h30);
        clean();

        // R9 acknowledge
        wr(1, 32'h0039_0000);
        waitc(2);
        irq_in[6] = 1'b1;
        waitc(2);
        irq_in[6] = 1'b0;
        waitc(8);
        check("R9 trigger raised", 32'(dma_trig), 32'b0010);
        check("R8 no cpu irq", 32'(cpu_irq), 32'd0);
        ack(4'b0001);
        waitc(3);
        check("R9 wrong ack ignored", 32'(dma_trig), 32'b0010);
        ack(4'b0010);
        waitc(3);
        check("R9 ack clears", 32'(dma_trig), 32'b0000);
        clean();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule